// File: doc/BRIEF.md
# Interrupt Coalescing Counter

This block decides when a DMA channel should raise its completion interrupts. Completed frames arrive as single-cycle pulses from the channel sequencer. Each pulse counts down a threshold counter. When the counter reaches zero, the block emits a completion-flag set pulse and refills the counter from the programmed threshold.

A one-shot delay timer runs beside the counter. It restarts on every completion that carries a nonzero delay value. When it runs out, it emits a delay-flag set pulse and refills the counter. Software can therefore ask for "an interrupt every N frames, or after a quiet period, whichever comes first".

The register block outside this unit supplies two inputs:
- the threshold field (control bits 23:16);
- the delay field (control bits 31:24).

It also supplies a strobe for every control write. This unit returns the live counter and timer values, which form status bits 31:16. Masking of the flags and the status register itself live elsewhere. The timer advances at a reference rate derived from the core clock by a parameterised divider. Its default is a 50 MHz reference rate from a 200 MHz clock.

Top module: `irq_coalesce`

## Requirements
- R1: After reset, cnt_o is 1, tmr_o is 0 and both set pulses are low, so that by default every completion raises the completion flag.
- R2: A cycle with ctrl_wr_i high and done_i low loads cnt_o from thr_i (control bits 23:16) at the next edge.
- R3: Each done_i pulse decrements the counter. A decrement that reaches zero drives ioc_set_o high for exactly the following cycle and refills cnt_o from thr_i.
- R4: When ctrl_wr_i and done_i arrive in the same cycle, the counter is first refilled from thr_i and then decremented.
- R5: A threshold of 0 makes the decrement wrap, so the next completion leaves cnt_o at 255.
- R6: A done_i pulse with dly_i (control bits 31:24) nonzero loads tmr_o with dly_i and restarts the divider, including when the timer is already running.
- R7: A running timer decrements once per CLK_HZ/REF_HZ cycles in which tick_i is high (4 with the defaults). When tick_i is low, the timer holds its value.
- R8: When the timer steps from 1 to 0, it stops at 0. dly_set_o is high for exactly the following cycle, and cnt_o refills from thr_i.
- R9: A done_i pulse with dly_i equal to 0 leaves the timer value and its countdown unchanged.
- R10: When a timer load and a timer expiry fall in the same cycle, the load wins: no dly_set_o pulse and no expiry refill of the counter.
- R11: When an expiry and a done_i pulse with zero dly_i fall in the same cycle, the counter is refilled and then decremented.
- R12: stat_o carries the timer in its upper byte and the counter in its lower byte (status bits 31:24 and 23:16).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_i | input | 8 | Completion threshold, control bits 23:16 |
| dly_i | input | 8 | Delay timer reload value, control bits 31:24 |
| ctrl_wr_i | input | 1 | High for one cycle on each control register write |
| done_i | input | 1 | Frame completion pulse from the sequencer |
| tick_i | input | 1 | Timer tick enable |
| ioc_set_o | output | 1 | Completion flag set pulse |
| dly_set_o | output | 1 | Delay flag set pulse |
| cnt_o | output | 8 | Current threshold counter |
| tmr_o | output | 8 | Current delay timer |
| stat_o | output | 16 | Status bits 31:16: timer byte above counter byte |

## Verification
The counter is visible on cnt_o one edge after any event. A wrong decrement, a missed refill or a wrong same-cycle ordering therefore shows as a wrong byte on the very next cycle. It also shifts every later ioc_set_o pulse.

A timer fault behaves differently. A divider that fails to restart, or an expiry that beats a load, stays hidden until the timer value next changes, up to four cycles later. At expiry it then shows as a misplaced or spurious dly_set_o pulse together with an unexpected counter refill. For this reason the timer checks sample both tmr_o between steps and the exact expiry cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   typedef enum logic {
      T_IDLE = 1'b0,
      T_RUN  = 1'b1
   } tmr_st_e;

   // Core-clock cycles per timer reference tick; guards a zero rate.
   function automatic int unsigned tick_ratio(input int unsigned clk_hz,
                                              input int unsigned ref_hz);
      return (ref_hz == 0) ? 1 : clk_hz / ref_hz;
   endfunction

endpackage

// File: rtl/irqc_thresh_cnt.sv
module irqc_thresh_cnt #(
   parameter int W       = 8,
   parameter int RST_VAL = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] thr_i,
   input  logic         wr_i,
   input  logic         done_i,
   input  logic         exp_i,
   output logic [W-1:0] cnt_o,
   output logic         hit_o
);

   logic [W-1:0] cnt_q, base, dec, cnt_d;
   logic         hit_d, hit_q;

   // Refill sources act first, then the completion decrement.
   always_comb begin
      base  = (wr_i || exp_i) ? thr_i : cnt_q;
      dec   = base - W'(1);
      cnt_d = base;
      hit_d = 1'b0;
      if (done_i) begin
         if (dec == '0) begin
            hit_d = 1'b1;
            cnt_d = thr_i;
         end else begin
            cnt_d = dec;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= W'(RST_VAL);
         hit_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         hit_q <= hit_d;
      end
   end

   assign cnt_o = cnt_q;
   assign hit_o = hit_q;

endmodule

// File: rtl/irqc_delay_tmr.sv
module irqc_delay_tmr
   import irqc_pkg::*;
#(
   parameter int W   = 8,
   parameter int DIV = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] dly_i,
   input  logic         done_i,
   input  logic         tick_i,
   output logic [W-1:0] tmr_o,
   output logic         exp_o,
   output logic         fire_o
);

   tmr_st_e      st_q;
   logic [W-1:0] tmr_q;
   logic         load, adv, stb, fire_q;

   assign load = done_i && (dly_i != '0);
   assign adv  = (st_q == T_RUN) && tick_i && !load;

   generate
      if (DIV == 1) begin : g_direct
         assign stb = adv;
      end else begin : g_div
         localparam int            PW   = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] pre_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pre_q <= '0;
            else if (load)
               pre_q <= '0;
            else if (adv)
               pre_q <= (pre_q == LAST) ? '0 : pre_q + PW'(1);
         end

         assign stb = adv && (pre_q == LAST);
      end
   endgenerate

   // A load in the same cycle suppresses stb, so the load wins.
   assign exp_o = stb && (tmr_q == W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_q  <= '0;
         st_q   <= T_IDLE;
         fire_q <= 1'b0;
      end else begin
         fire_q <= exp_o;
         if (load) begin
            tmr_q <= dly_i;
            st_q  <= T_RUN;
         end else if (stb) begin
            tmr_q <= tmr_q - W'(1);
            if (exp_o)
               st_q <= T_IDLE;
         end
      end
   end

   assign tmr_o  = tmr_q;
   assign fire_o = fire_q;

endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce
   import irqc_pkg::*;
#(
   parameter int FLD_W   = 8,
   parameter int CLK_HZ  = 200_000_000,
   parameter int REF_HZ  = 50_000_000,
   parameter int RST_THR = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FLD_W-1:0]   thr_i,
   input  logic [FLD_W-1:0]   dly_i,
   input  logic               ctrl_wr_i,
   input  logic               done_i,
   input  logic               tick_i,
   output logic               ioc_set_o,
   output logic               dly_set_o,
   output logic [FLD_W-1:0]   cnt_o,
   output logic [FLD_W-1:0]   tmr_o,
   output logic [2*FLD_W-1:0] stat_o
);

   localparam int DIV = int'(tick_ratio(CLK_HZ, REF_HZ));

   generate
      if (FLD_W < 1 || FLD_W > 16) begin : g_bad_width
         $error("irq_coalesce: FLD_W out of range");
      end
      if (REF_HZ <= 0 || CLK_HZ < REF_HZ || (CLK_HZ % REF_HZ) != 0) begin : g_bad_rate
         $error("irq_coalesce: CLK_HZ must be a whole multiple of REF_HZ");
      end
      if (RST_THR < 0 || RST_THR >= (1 << FLD_W)) begin : g_bad_rst
         $error("irq_coalesce: RST_THR does not fit the threshold field");
      end
   endgenerate

   logic tmr_exp;

   irqc_delay_tmr #(
      .W   (FLD_W),
      .DIV (DIV)
   ) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .dly_i  (dly_i),
      .done_i (done_i),
      .tick_i (tick_i),
      .tmr_o  (tmr_o),
      .exp_o  (tmr_exp),
      .fire_o (dly_set_o)
   );

   irqc_thresh_cnt #(
      .W       (FLD_W),
      .RST_VAL (RST_THR)
   ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .thr_i  (thr_i),
      .wr_i   (ctrl_wr_i),
      .done_i (done_i),
      .exp_i  (tmr_exp),
      .cnt_o  (cnt_o),
      .hit_o  (ioc_set_o)
   );

   assign stat_o = {tmr_o, cnt_o};

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
   parameter int FLD_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [FLD_W-1:0] thr_i,
   input logic [FLD_W-1:0] dly_i,
   input logic             ctrl_wr_i,
   input logic             done_i,
   input logic             tick_i,
   input logic             ioc_set_o,
   input logic             dly_set_o,
   input logic [FLD_W-1:0] cnt_o,
   input logic [FLD_W-1:0] tmr_o
);

   p_wr_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr_i && !done_i) |=> (cnt_o == $past(thr_i)));

   p_ioc_refill_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ioc_set_o |-> (cnt_o == $past(thr_i)));

   p_zero_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr_i && done_i && thr_i == '0) |=> (cnt_o == '1));

   // R6 and R10: a load always lands and is never reported as an expiry.
   p_load_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && dly_i != '0) |=> (tmr_o == $past(dly_i) && !dly_set_o));

   p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !done_i) |=> $stable(tmr_o));

   p_expiry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dly_set_o |-> (tmr_o == '0 && $past(tmr_o) == FLD_W'(1)));

   p_zero_dly_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && dly_i == '0 && tmr_o == '0) |=> (tmr_o == '0));

endmodule

bind irq_coalesce irqc_chk #(
   .FLD_W (FLD_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .thr_i     (thr_i),
   .dly_i     (dly_i),
   .ctrl_wr_i (ctrl_wr_i),
   .done_i    (done_i),
   .tick_i    (tick_i),
   .ioc_set_o (ioc_set_o),
   .dly_set_o (dly_set_o),
   .cnt_o     (cnt_o),
   .tmr_o     (tmr_o)
);

// File: tb/tb_irq_coalesce.sv
`timescale 1ns/1ps
module tb_irq_coalesce;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  thr_i = '0;
   logic [7:0]  dly_i = '0;
   logic        ctrl_wr_i = 1'b0;
   logic        done_i = 1'b0;
   logic        tick_i = 1'b0;
   logic        ioc_set_o, dly_set_o;
   logic [7:0]  cnt_o, tmr_o;
   logic [15:0] stat_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   irq_coalesce dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .thr_i     (thr_i),
      .dly_i     (dly_i),
      .ctrl_wr_i (ctrl_wr_i),
      .done_i    (done_i),
      .tick_i    (tick_i),
      .ioc_set_o (ioc_set_o),
      .dly_set_o (dly_set_o),
      .cnt_o     (cnt_o),
      .tmr_o     (tmr_o),
      .stat_o    (stat_o)
   );

   typedef struct packed {
      logic [7:0] thr;
      logic       wr;
      logic       done;
      logic       ioc;
      logic [7:0] cnt;
   } vec_t;

   // Counter vectors, timer idle (delay field 0, tick low).
   localparam vec_t VT [0:13] = '{
      '{8'd3, 1'b1, 1'b0, 1'b0, 8'd3},    // R2 write
      '{8'd3, 1'b0, 1'b1, 1'b0, 8'd2},    // R3
      '{8'd3, 1'b0, 1'b1, 1'b0, 8'd1},    // R3
      '{8'd3, 1'b0, 1'b1, 1'b1, 8'd3},    // R3 hit and refill
      '{8'd3, 1'b0, 1'b0, 1'b0, 8'd3},    // R3 single pulse
      '{8'd5, 1'b1, 1'b1, 1'b0, 8'd4},    // R4 refill then decrement
      '{8'd5, 1'b0, 1'b1, 1'b0, 8'd3},
      '{8'd1, 1'b1, 1'b0, 1'b0, 8'd1},    // R2
      '{8'd1, 1'b0, 1'b1, 1'b1, 8'd1},    // R3 threshold one
      '{8'd1, 1'b0, 1'b1, 1'b1, 8'd1},
      '{8'd0, 1'b1, 1'b0, 1'b0, 8'd0},    // R5 setup
      '{8'd0, 1'b0, 1'b1, 1'b0, 8'd255},  // R5 wrap
      '{8'd2, 1'b1, 1'b1, 1'b0, 8'd1},    // R4
      '{8'd2, 1'b0, 1'b1, 1'b1, 8'd2}     // R3
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Drive for one cycle from a falling edge; return at the next falling edge.
   task automatic step(input logic [7:0] thr, input logic [7:0] dly,
                       input logic wr, input logic dn, input logic tk);
      thr_i = thr; dly_i = dly; ctrl_wr_i = wr; done_i = dn; tick_i = tk;
      @(negedge clk);
      ctrl_wr_i = 1'b0; done_i = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      bit seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 cnt", 16'(cnt_o), 16'd1);
      chk("R1 tmr", 16'(tmr_o), 16'd0);
      chk("R1 flags", {14'd0, ioc_set_o, dly_set_o}, 16'd0);
      step(8'd0, 8'd0, 1'b0, 1'b1, 1'b0);
      chk("R1 first completion flags", 16'(ioc_set_o), 16'd1);

      for (int i = 0; i < 14; i++) begin
         step(VT[i].thr, 8'd0, VT[i].wr, VT[i].done, 1'b0);
         chk($sformatf("R2 R3 R4 R5 row %0d cnt", i), 16'(cnt_o), 16'(VT[i].cnt));
         chk($sformatf("R3 row %0d ioc", i), 16'(ioc_set_o), 16'(VT[i].ioc));
         chk($sformatf("R9 row %0d timer idle", i), {7'd0, dly_set_o, tmr_o}, 16'd0);
      end

      // Timer countdown and expiry: threshold 4, delay 2.
      step(8'd4, 8'd2, 1'b1, 1'b0, 1'b1);
      chk("R2 cnt", 16'(cnt_o), 16'd4);
      step(8'd4, 8'd2, 1'b0, 1'b1, 1'b1);
      chk("R6 load", stat_o, 16'h0203);
      for (int k = 1; k <= 9; k++) begin
         step(8'd4, 8'd2, 1'b0, 1'b0, 1'b1);
         if (k == 3) chk("R7 holds until divider wraps", 16'(tmr_o), 16'd2);
         if (k == 4) chk("R12 status word", stat_o, 16'h0103);
         if (k == 7) chk("R7 no early expiry", {7'd0, dly_set_o, tmr_o}, 16'h0001);
         if (k == 8) begin
            chk("R8 expiry pulse", 16'(dly_set_o), 16'd1);
            chk("R8 refill", stat_o, 16'h0004);
         end
         if (k == 9) chk("R8 single pulse", {7'd0, dly_set_o, tmr_o}, 16'd0);
      end

      // Restart of a running timer.
      step(8'd4, 8'd2, 1'b0, 1'b1, 1'b1);
      seen = 1'b0;
      for (int k = 1; k <= 5; k++) begin
         step(8'd4, 8'd2, 1'b0, 1'b0, 1'b1);
         seen |= dly_set_o;
      end
      step(8'd4, 8'd2, 1'b0, 1'b1, 1'b1);
      chk("R6 restart", stat_o, 16'h0202);
      for (int k = 1; k <= 7; k++) begin
         step(8'd4, 8'd2, 1'b0, 1'b0, 1'b1);
         seen |= dly_set_o;
      end
      chk("R6 old deadline cancelled", 16'(seen), 16'd0);
      step(8'd4, 8'd2, 1'b0, 1'b0, 1'b1);
      chk("R8 expiry after restart", {7'd0, dly_set_o, cnt_o}, 16'h0104);

      // Tick low freezes the timer.
      step(8'd4, 8'd2, 1'b0, 1'b1, 1'b0);
      seen = 1'b0;
      for (int k = 1; k <= 10; k++) begin
         step(8'd4, 8'd2, 1'b0, 1'b0, 1'b0);
         seen |= dly_set_o;
      end
      chk("R7 frozen", {7'd0, seen, tmr_o}, 16'h0002);

      // Load and expiry in the same cycle.
      for (int k = 1; k <= 7; k++) step(8'd4, 8'd2, 1'b0, 1'b0, 1'b1);
      chk("R10 setup", 16'(tmr_o), 16'd1);
      step(8'd4, 8'd2, 1'b0, 1'b1, 1'b1);
      chk("R10 load wins", {7'd0, dly_set_o, tmr_o}, 16'h0002);
      chk("R10 no expiry refill", 16'(cnt_o), 16'd2);
      step(8'd4, 8'd2, 1'b0, 1'b0, 1'b0);
      chk("R10 no late pulse", 16'(dly_set_o), 16'd0);

      // Zero-delay completion, then expiry meeting a completion.
      step(8'd4, 8'd3, 1'b1, 1'b0, 1'b0);
      step(8'd4, 8'd3, 1'b0, 1'b1, 1'b0);
      chk("R6 load three", stat_o, 16'h0303);
      step(8'd4, 8'd0, 1'b0, 1'b0, 1'b1);
      step(8'd4, 8'd0, 1'b0, 1'b1, 1'b1);
      chk("R9 zero delay keeps timer", stat_o, 16'h0302);
      for (int k = 3; k <= 11; k++) step(8'd4, 8'd0, 1'b0, 1'b0, 1'b1);
      chk("R9 countdown kept", 16'(tmr_o), 16'd1);
      step(8'd4, 8'd0, 1'b0, 1'b1, 1'b1);
      chk("R11 expiry with completion", {6'd0, ioc_set_o, dly_set_o, cnt_o}, 16'h0103);
      chk("R11 timer stopped", 16'(tmr_o), 16'd0);

      finish_run();
   end

endmodule